// File: doc/BRIEF.md
# Pattern-Unlocked Serial Real-Time Clock

This block is a calendar clock that sits behind a single memory location. Each bus access carries one data bit. Until the block recognises an unlock sequence, it stays out of the way and every access goes through to the memory that shares the location. To open the clock, software first issues a read, which arms the recogniser. It then issues 64 writes whose data bits must equal a fixed key. After that, the next 64 accesses move the clock's eight BCD time registers one bit at a time. Each of these accesses can be a read or a write.

When the key completes, the block copies the running counters into a 64-bit transfer image. Reads shift that image out. Writes replace bits of it. If any write happened during the 64-access transfer, the image is copied into the counters when the transfer ends. A tick input advances the counters by one hundredth of a second. The counters cover 12- and 24-hour formats, month lengths, leap years, and a stop bit that freezes them.

Top module: `keyed_serial_rtc`

## Requirements
- R1: After reset, the recogniser is disarmed and the clock reads 00:00:00.00 in 24-hour mode, with weekday 1, date 01, month 01 and year 00. dataOe is low.
- R2: An access is a cycle with ceN low and at least one of weN or oeN low. If weN is low, the access is a write (write wins when both strobes are low). Otherwise it is a read. memPass is high for every access except those in the transfer phase. dataOut is 0 except during a transfer read.
- R3: A read outside the transfer phase arms the recogniser and restarts it at key bit 0, even in the middle of a key.
- R4: The key is the bytes C5h, 3Ah, A3h, 5Ch, C5h, 3Ah, A3h, 5Ch, sent in that order, each byte least significant bit first. When the 64th write matches, the transfer phase starts.
- R5: A write whose bit differs from the expected key bit disarms the recogniser. Writes to a disarmed recogniser are ignored until a read arms it again.
- R6: On the edge that completes the key, the transfer image takes the counter values from before any tick in that same cycle.
- R7: Transfer access n (0..63) carries bit n mod 8 of register n div 8. A read drives that image bit on dataOut with dataOe high in the same cycle. A write replaces that image bit.
- R8: After the 64th transfer access, the block is disarmed again. If any of the 64 accesses was a write, the counters take the whole image, including the last bit. This load takes priority over a tick in the same cycle. A transfer made only of reads leaves the counters running undisturbed.
- R9: The registers are, in order: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year, all BCD. In the hours register, bit 7 selects 12-hour mode and bit 5 is PM. In the weekday register, the weekday is in bits 2:0 and bit 5 stops the clock.
- R10: A tick adds one hundredth. Carries run 99 hundredths to seconds, 59 seconds to minutes, 59 minutes to hours, and in 24-hour mode 23 hours to 00 with a carry into the day.
- R11: In 12-hour mode, 11 becomes 12 and toggles PM. Only 11 PM to 12 AM carries into the day. 12 becomes 01 with PM unchanged.
- R12: The weekday wraps from 7 to 1. The date wraps after 30 or 31 according to the month. February has 29 days when the year is divisible by 4, otherwise 28. The month wraps from 12 to 01, and the year wraps from 99 to 00.
- R13: While the stop bit is set, ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable of the shared location |
| weN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low read strobe |
| dataIn | input | 1 | Data bit of a write access |
| tick | input | 1 | One-hundredth-second advance pulse |
| dataOut | output | 1 | Image bit on a transfer read, otherwise 0 |
| dataOe | output | 1 | High while the block drives a transfer read |
| memPass | output | 1 | High when the access belongs to the shared memory |

## Verification
The outputs memPass, dataOe and dataOut are decoded from the current access and the registered phase, so they are due in the same cycle as the access. The bench samples them two nanoseconds after the falling edge. Changes of phase, bit index, image and counters happen at the following rising edge and show up from the next access on. The reference model in the bench therefore updates its state just after that edge, using the inputs that were held before it. A tick takes effect on the counters at the end of its own cycle. The bench observes a tick's result only through the snapshot taken by a later full unlock, so every time check reads a complete 64-access image after the tick cycles have ended.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  localparam int KEY_LEN = 64;
  localparam int IMG_LEN = 64;
  localparam int IDX_W   = $clog2(KEY_LEN);
  localparam int REG_W   = 8;

  localparam logic [IMG_LEN-1:0] RESET_TIME = 64'h00010101_00000000;

  typedef enum logic [1:0] {PH_IDLE, PH_KEY, PH_XFER} phase_t;

  typedef struct packed {
    logic             snap;
    logic             bitWr;
    logic             load;
    logic             rdEn;
    logic             xfer;
    logic [IDX_W-1:0] bitIdx;
  } rtcStrb_t;

  function automatic logic [REG_W-1:0] toBcd(input int unsigned v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int unsigned fromBcd(input logic [REG_W-1:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int unsigned monthLen(input int unsigned mo, input int unsigned yr);
    int unsigned len;
    case (mo)
      4, 6, 9, 11: len = 30;
      2:           len = (yr % 4 == 0) ? 29 : 28;
      default:     len = 31;
    endcase
    return len;
  endfunction

  function automatic logic [IMG_LEN-1:0] advanceTime(input logic [IMG_LEN-1:0] t);
    logic [IMG_LEN-1:0] n;
    logic [REG_W-1:0]   b;
    logic               carry;
    int unsigned        v, len;
    n = t;
    // hundredths
    v = fromBcd(t[7:0]);
    if (v >= 99) begin n[7:0] = 8'h00; carry = 1'b1; end
    else begin n[7:0] = toBcd(v + 1); carry = 1'b0; end
    // seconds
    if (carry) begin
      v = fromBcd(t[15:8]);
      if (v >= 59) n[15:8] = 8'h00;
      else begin n[15:8] = toBcd(v + 1); carry = 1'b0; end
    end
    // minutes
    if (carry) begin
      v = fromBcd(t[23:16]);
      if (v >= 59) n[23:16] = 8'h00;
      else begin n[23:16] = toBcd(v + 1); carry = 1'b0; end
    end
    // hours
    if (carry) begin
      if (t[31]) begin
        v = fromBcd({3'b000, t[28:24]});
        if (v == 11) begin
          b = toBcd(12);
          n[31:24] = {1'b1, 1'b0, ~t[29], b[4:0]};
          carry = t[29];
        end else if (v >= 12) begin
          b = toBcd(1);
          n[31:24] = {1'b1, 1'b0, t[29], b[4:0]};
          carry = 1'b0;
        end else begin
          b = toBcd(v + 1);
          n[31:24] = {1'b1, 1'b0, t[29], b[4:0]};
          carry = 1'b0;
        end
      end else begin
        v = fromBcd({2'b00, t[29:24]});
        if (v >= 23) n[31:24] = 8'h00;
        else begin n[31:24] = toBcd(v + 1); carry = 1'b0; end
      end
    end
    // weekday and date
    if (carry) begin
      v = int'(t[34:32]);
      n[39:32] = {2'b00, t[37], 2'b00, (v >= 7) ? 3'd1 : 3'(v + 1)};
      len = monthLen(fromBcd({3'b000, t[52:48]}), fromBcd(t[63:56]));
      v = fromBcd({2'b00, t[45:40]});
      if (v >= len) n[47:40] = 8'h01;
      else begin n[47:40] = toBcd(v + 1); carry = 1'b0; end
    end
    // month
    if (carry) begin
      v = fromBcd({3'b000, t[52:48]});
      if (v >= 12) n[55:48] = 8'h01;
      else begin n[55:48] = toBcd(v + 1); carry = 1'b0; end
    end
    // year
    if (carry) begin
      v = fromBcd(t[63:56]);
      n[63:56] = (v >= 99) ? 8'h00 : toBcd(v + 1);
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter logic [KEY_LEN-1:0] KEY = 64'h5CA33AC5_5CA33AC5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     isWr,
  input  logic     isRd,
  input  logic     din,
  output rtcStrb_t strb
);

  phase_t           phase;
  logic [IDX_W-1:0] idx;
  logic             wrote;
  logic             lastIdx;
  logic             keyHit;

  assign lastIdx = (idx == IDX_W'(KEY_LEN - 1));
  assign keyHit  = (din == KEY[idx]);

  always_comb begin
    strb.xfer   = (phase == PH_XFER);
    strb.snap   = (phase == PH_KEY) && isWr && keyHit && lastIdx;
    strb.bitWr  = (phase == PH_XFER) && isWr;
    strb.rdEn   = (phase == PH_XFER) && isRd;
    strb.load   = (phase == PH_XFER) && (isWr || isRd) && lastIdx && (wrote || isWr);
    strb.bitIdx = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      idx   <= '0;
      wrote <= 1'b0;
    end else begin
      case (phase)
        PH_XFER: begin
          if (isWr || isRd) begin
            if (lastIdx) begin
              phase <= PH_IDLE;
              idx   <= '0;
              wrote <= 1'b0;
            end else begin
              idx   <= idx + 1'b1;
              wrote <= wrote | isWr;
            end
          end
        end
        default: begin
          if (isRd) begin
            phase <= PH_KEY;
            idx   <= '0;
          end else if (isWr && phase == PH_KEY) begin
            if (!keyHit) begin
              phase <= PH_IDLE;
              idx   <= '0;
            end else if (lastIdx) begin
              phase <= PH_XFER;
              idx   <= '0;
              wrote <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/rtc_datapath.sv
`timescale 1ns/1ps
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  rtcStrb_t           strb,
  input  logic               din,
  input  logic               tick,
  output logic               rdBit,
  output logic [IMG_LEN-1:0] timeNow
);

  localparam int STOP_BIT = 4 * REG_W + 5;

  logic [IMG_LEN-1:0] image;
  logic [IMG_LEN-1:0] nextImg;
  logic [IMG_LEN-1:0] timeReg;

  always_comb begin
    nextImg = image;
    if (strb.bitWr) nextImg[strb.bitIdx] = din;
  end

  assign rdBit   = image[strb.bitIdx];
  assign timeNow = timeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      image <= '0;
    end else if (strb.snap) begin
      image <= timeReg;
    end else if (strb.bitWr) begin
      image <= nextImg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeReg <= RESET_TIME;
    end else if (strb.load) begin
      timeReg <= nextImg;
    end else if (tick && !timeReg[STOP_BIT]) begin
      timeReg <= advanceTime(timeReg);
    end
  end

endmodule

// File: rtl/keyed_serial_rtc.sv
`timescale 1ns/1ps
module keyed_serial_rtc
  import rtc_pkg::*;
#(
  parameter logic [KEY_LEN-1:0] KEY = 64'h5CA33AC5_5CA33AC5
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic weN,
  input  logic oeN,
  input  logic dataIn,
  input  logic tick,
  output logic dataOut,
  output logic dataOe,
  output logic memPass
);

  logic               access;
  logic               isWr;
  logic               isRd;
  logic               rdBit;
  rtcStrb_t           strb;
  logic [IMG_LEN-1:0] curTime;

  assign access = !ceN && (!weN || !oeN);
  assign isWr   = access && !weN;
  assign isRd   = access && weN && !oeN;

  rtc_ctrl #(.KEY(KEY)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .isWr (isWr),
    .isRd (isRd),
    .din  (dataIn),
    .strb (strb)
  );

  rtc_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .din     (dataIn),
    .tick    (tick),
    .rdBit   (rdBit),
    .timeNow (curTime)
  );

  assign dataOe  = strb.rdEn;
  assign dataOut = strb.rdEn & rdBit;
  assign memPass = access && !strb.xfer;

endmodule

// File: rtl/keyed_serial_rtc_sva.sv
`timescale 1ns/1ps
module keyed_serial_rtc_sva
  import rtc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               ceN,
  input logic               weN,
  input logic               oeN,
  input logic               tick,
  input logic               dataOe,
  input logic               memPass,
  input rtcStrb_t           strb,
  input logic [IMG_LEN-1:0] curTime
);

  a_r2_owner_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(dataOe && memPass));

  a_r2_deselected_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (!memPass && !dataOe));

  a_r3_read_rearms: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && weN && !oeN && !strb.xfer) |=> !strb.xfer);

  a_r6_snap_opens: assert property (@(posedge clk) disable iff (!rstN)
    strb.snap |=> strb.xfer);

  a_r7_snap_not_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.snap, strb.bitWr}));

  a_r8_load_closes: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !strb.xfer);

  a_r10_hundredths_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !curTime[37] && !strb.load && curTime[7:0] == 8'h99) |=> (curTime[7:0] == 8'h00));

  a_r13_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (curTime[37] && !strb.load) |=> $stable(curTime));

endmodule

bind keyed_serial_rtc keyed_serial_rtc_sva u_sva (
  .clk     (clk),
  .rstN    (rstN),
  .ceN     (ceN),
  .weN     (weN),
  .oeN     (oeN),
  .tick    (tick),
  .dataOe  (dataOe),
  .memPass (memPass),
  .strb    (strb),
  .curTime (curTime)
);

// File: tb/tb_keyed_serial_rtc.sv
`timescale 1ns/1ps
module tb_keyed_serial_rtc;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, dataIn = 1'b0, tick = 1'b0;
  wire  dataOut, dataOe, memPass;

  always #4 clk = ~clk;

  keyed_serial_rtc dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .dataIn(dataIn), .tick(tick),
    .dataOut(dataOut), .dataOe(dataOe), .memPass(memPass)
  );

  int nChk = 0;
  int nFail = 0;
  int oeSeen = 0;
  string curTag = "R1";
  logic lastOut, lastPass;

  // reference model state
  int          mSt = 0;     // 0 disarmed, 1 matching key, 2 transfer
  int          mIdx = 0;
  bit          mWrote = 0;
  logic [63:0] mImg = '0;
  logic [63:0] mTime = 64'h00010101_00000000;

  function automatic bit keyBit(input int i);
    logic [7:0] pat [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
    return pat[(i / 8) % 4][i % 8];
  endfunction

  function automatic int d2i(input logic [7:0] b);
    return (b / 16) * 10 + (b % 16);
  endfunction

  function automatic logic [7:0] i2d(input int x);
    return 8'((x / 10) * 16 + x % 10);
  endfunction

  function automatic logic [63:0] mdlAdvance(input logic [63:0] t);
    logic [63:0] r = t;
    int ml [12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};
    int hs = d2i(t[7:0]) + 1;
    int sc = d2i(t[15:8]);
    int mn = d2i(t[23:16]);
    int hr, dy, dt, mo, yr, lim;
    bit pm;
    r[7:0] = i2d(hs % 100);
    if (hs < 100) return r;
    sc++; r[15:8] = i2d(sc % 60);
    if (sc < 60) return r;
    mn++; r[23:16] = i2d(mn % 60);
    if (mn < 60) return r;
    if (t[31]) begin
      hr = d2i({3'b000, t[28:24]});
      pm = t[29];
      if (hr == 11) begin
        pm = !pm;
        r[31:24] = 8'h80 | (pm ? 8'h20 : 8'h00) | i2d(12);
        if (pm) return r;
      end else if (hr == 12) begin
        r[31:24] = 8'h80 | (pm ? 8'h20 : 8'h00) | i2d(1);
        return r;
      end else begin
        r[31:24] = 8'h80 | (pm ? 8'h20 : 8'h00) | i2d(hr + 1);
        return r;
      end
    end else begin
      hr = d2i({2'b00, t[29:24]}) + 1;
      r[31:24] = i2d(hr % 24);
      if (hr < 24) return r;
    end
    dy = int'(t[34:32]) % 7 + 1;
    r[39:32] = {2'b00, t[37], 2'b00, 3'(dy)};
    dt = d2i({2'b00, t[45:40]}) + 1;
    mo = d2i({3'b000, t[52:48]});
    yr = d2i(t[63:56]);
    lim = (mo < 1 || mo > 12) ? 31 : ml[mo - 1] + ((mo == 2 && yr % 4 == 0) ? 1 : 0);
    if (dt <= lim) begin r[47:40] = i2d(dt); return r; end
    r[47:40] = 8'h01;
    mo++;
    if (mo <= 12) begin r[55:48] = i2d(mo); return r; end
    r[55:48] = 8'h01;
    r[63:56] = i2d((yr + 1) % 100);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit w, input bit o, input bit d, input bit t);
    bit acc, wr, rd, eOe, eOut, ePass, ld;
    @(negedge clk);
    ceN = c; weN = w; oeN = o; dataIn = d; tick = t;
    #2;
    acc   = !c && (!w || !o);
    wr    = acc && !w;
    rd    = acc && w && !o;
    eOe   = (mSt == 2) && rd;
    eOut  = eOe ? mImg[mIdx] : 1'b0;
    ePass = acc && (mSt != 2);
    lastOut  = dataOut;
    lastPass = memPass;
    if (dataOe === 1'b1) oeSeen++;
    nChk++;
    if ({dataOut, dataOe, memPass} !== {eOut, eOe, ePass}) begin
      nFail++;
      $display("FAIL %s per-cycle out/oe/pass act=%b%b%b exp=%b%b%b",
               curTag, dataOut, dataOe, memPass, eOut, eOe, ePass);
    end
    @(posedge clk);
    ld = 1'b0;
    if (mSt == 2) begin
      if (acc) begin
        if (wr) mImg[mIdx] = d;
        mWrote = mWrote | wr;
        if (mIdx == 63) begin
          mSt = 0; mIdx = 0;
          if (mWrote) begin mTime = mImg; ld = 1'b1; end
          mWrote = 0;
        end else mIdx++;
      end
    end else if (rd) begin
      mSt = 1; mIdx = 0;
    end else if (wr && mSt == 1) begin
      if (d == keyBit(mIdx)) begin
        if (mIdx == 63) begin mSt = 2; mIdx = 0; mImg = mTime; mWrote = 0; end
        else mIdx++;
      end else begin
        mSt = 0; mIdx = 0;
      end
    end
    if (t && !ld && !mTime[37]) mTime = mdlAdvance(mTime);
  endtask

  task automatic rdAcc(); cyc(0, 1, 0, 0, 0); endtask
  task automatic wrAcc(input bit d); cyc(0, 0, 1, d, 0); endtask
  task automatic idleTick(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 0, 1);
  endtask

  task automatic sendKey(input bit tickLast, input bit bothLow);
    for (int i = 0; i < 64; i++) cyc(0, 0, bothLow ? 1'b0 : 1'b1, keyBit(i), tickLast && (i == 63));
  endtask

  task automatic readAll(output logic [63:0] v);
    for (int i = 0; i < 64; i++) begin rdAcc(); v[i] = lastOut; end
  endtask

  task automatic writeAll(input logic [63:0] v);
    for (int i = 0; i < 64; i++) wrAcc(v[i]);
  endtask

  task automatic getTime(output logic [63:0] v);
    rdAcc(); sendKey(0, 0); readAll(v);
  endtask

  task automatic setTime(input logic [63:0] v);
    rdAcc(); sendKey(0, 0); writeAll(v);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    curTag = "R1";
    cyc(1, 1, 1, 0, 0);
    chk("R1 idle dataOe", 64'(dataOe), 64'd0);
    getTime(v);
    chk("R1 reset time", v, 64'h00010101_00000000);

    // R2 R4: key written with both strobes low counts as writes
    curTag = "R4";
    rdAcc(); sendKey(0, 1); readAll(v);
    chk("R2 R4 unlock with write precedence", v, 64'h00010101_00000000);

    // R2: deselected access is not an access
    curTag = "R2";
    cyc(1, 0, 0, 1, 0);
    chk("R2 ceN high no pass", 64'(lastPass), 64'd0);
    wrAcc(1);
    chk("R2 write passes to memory", 64'(lastPass), 64'd1);

    // R3: read mid-key restarts recogniser
    curTag = "R3";
    rdAcc();
    for (int i = 0; i < 20; i++) wrAcc(keyBit(i));
    rdAcc(); sendKey(0, 0); readAll(v);
    chk("R3 restart after mid-key read", v, 64'h00010101_00000000);

    // R5: mismatch disarms, later writes ignored
    curTag = "R5";
    oeSeen = 0;
    rdAcc();
    for (int i = 0; i < 10; i++) wrAcc(keyBit(i));
    wrAcc(!keyBit(10));
    for (int i = 11; i < 64; i++) wrAcc(keyBit(i));
    wrAcc(0);
    chk("R5 still passing after bad key", 64'(lastPass), 64'd1);
    chk("R5 no transfer after bad key", 64'(oeSeen), 64'd0);

    // R10 R12 R8: full rollover into March
    curTag = "R10";
    setTime(64'h23_02_28_07_23_59_59_99);
    idleTick(1);
    getTime(v);
    chk("R10 R12 R8 rollover to 1 March", v, 64'h23_03_01_01_00_00_00_00);

    curTag = "R12";
    setTime(64'h24_02_28_03_23_59_59_99);
    idleTick(1);
    getTime(v);
    chk("R12 leap February 29", v, 64'h24_02_29_04_00_00_00_00);

    setTime(64'h99_12_31_02_23_59_59_99);
    idleTick(1);
    getTime(v);
    chk("R12 year wrap", v, 64'h00_01_01_03_00_00_00_00);

    // R11: 12-hour mode
    curTag = "R11";
    setTime(64'h24_05_15_03_91_59_59_99);
    idleTick(1);
    getTime(v);
    chk("R11 11AM to 12PM", v, 64'h24_05_15_03_B2_00_00_00);
    setTime(64'h24_05_15_03_B1_59_59_99);
    idleTick(1);
    getTime(v);
    chk("R11 11PM to 12AM next day", v, 64'h24_05_16_04_92_00_00_00);
    setTime(64'h24_05_15_03_B2_59_59_99);
    idleTick(1);
    getTime(v);
    chk("R11 12PM to 1PM", v, 64'h24_05_15_03_A1_00_00_00);

    // R13 R9: stop bit in weekday register
    curTag = "R13";
    setTime(64'h24_05_15_25_10_20_30_40);
    idleTick(5);
    getTime(v);
    chk("R13 stopped clock holds", v, 64'h24_05_15_25_10_20_30_40);

    // R10 R8: read-only transfer does not load
    curTag = "R8";
    setTime(64'h24_05_15_03_10_20_30_40);
    idleTick(3);
    getTime(v);
    chk("R10 three ticks", v, 64'h24_05_15_03_10_20_30_43);
    rdAcc(); sendKey(0, 0);
    for (int i = 0; i < 64; i++) begin cyc(0, 1, 0, 0, 1); v[i] = lastOut; end
    chk("R7 image is the snapshot", v, 64'h24_05_15_03_10_20_30_43);
    getTime(v);
    chk("R8 read-only transfer keeps counting", v, 64'h24_05_15_03_10_20_31_07);

    // R6: tick on key-completing edge
    curTag = "R6";
    rdAcc(); sendKey(1, 0); readAll(v);
    chk("R6 snapshot before tick", v, 64'h24_05_15_03_10_20_31_07);
    getTime(v);
    chk("R6 tick applied to counters", v, 64'h24_05_15_03_10_20_31_08);

    // R7: partial write of register 0 only
    curTag = "R7";
    rdAcc(); sendKey(0, 0);
    for (int i = 0; i < 64; i++) begin
      if (i < 8) wrAcc(((8'h55 >> i) & 1) != 0);
      else rdAcc();
    end
    getTime(v);
    chk("R7 R8 mixed transfer writes register 0", v, 64'h24_05_15_03_10_20_31_55);

    // R8: load on last bit beats tick
    curTag = "R8";
    v = 64'h24_05_15_03_10_20_30_40;
    rdAcc(); sendKey(0, 0);
    for (int i = 0; i < 64; i++) cyc(0, 0, 1, v[i], i == 63);
    getTime(v);
    chk("R8 load overrides tick", v, 64'h24_05_15_03_10_20_30_40);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule